// File: doc/BRIEF.md
# Dual-pass checked trinomial field multiplier

This block multiplies two elements of GF(2^WIDTH), with the field defined by the trinomial x^WIDTH + x^TAP + 1 (0 < TAP < WIDTH), and checks every product for faults while it runs. A single combinational array of multiply-accumulate cells is used twice for each operation. The first pass uses the ordinary reduction feedback on the operands as given. The second pass feeds the array a cyclically rotated copy of the second operand and switches the reduction feedback to its alternate tap. This yields the same product, rotated by TAP bit positions. The first result is latched. The second result is re-indexed back into the normal bit order and compared bit by bit with the latched one. Each row of the array also compares the multiplier bit that enters the row with the bit that leaves its last cell.

A caller pulses `start` with both operands present. Two clock edges later the block pulses `done` and presents either the checked product or, if any check failed, a raised `error` with the product forced to zero. A new operation may be accepted in the cycle of the second pass, so checked results can follow each other every two cycles.

Top module: `dpc_mul`

## Requirements
- R1: While reset is applied and after it is released, with no operation started, `done`, `error` and `product` are all zero.
- R2: With no fault present, `product` equals op_a times op_b reduced modulo x^WIDTH + x^TAP + 1, and `error` is 0. Bit k of each vector is the coefficient of x^k.
- R3: `start` is accepted on a rising edge when no first pass is in progress. `done` is high for exactly one cycle, from the second rising edge after the accepting edge.
- R4: A `start` accepted during the second pass of the previous operation is processed, and the two results appear on `done` pulses two cycles apart.
- R5: A `start` seen while a first pass is in progress is ignored. No extra `done` appears, and the running operation's result is not altered.
- R6: The second pass works on the rotated operand v_i = b_((i+TAP) mod WIDTH). Its result r' is realigned as c_k = r'_((k-TAP) mod WIDTH). When the realigned result and the first result match and no row check failed, `error` stays 0.
- R7: When `error` is 1, `product` is all zeros.
- R8: `product` and `error` change only on a `done` cycle and hold their values between completions, whatever the operand inputs do.
- R9: A stuck-at-0 or stuck-at-1 on the accumulate output of any array cell raises `error` on every operation where it changes a result bit in either pass. An operation that ends without `error` under such a fault delivers the correct product.
- R10: A stuck value on the pass-through multiplier-bit output of a cell in row i raises `error` exactly when it differs from op_a bit i. Otherwise the product is correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin one checked multiplication |
| op_a | input | WIDTH | Multiplier operand, sampled when start is accepted |
| op_b | input | WIDTH | Multiplicand operand, sampled when start is accepted |
| done | output | 1 | One-cycle pulse marking a finished operation |
| product | output | WIDTH | Checked product, zero when error is set |
| error | output | 1 | Set when the two passes disagree or a row check failed |

## Verification
A bad sequencer state would show up at the ports within the operation it hits. A `done` pulse would come early, late, doubled or not at all, measured against the fixed two-edge latency, or a product would be taken from the wrong operand pair. A corrupted first-pass latch, a wrong rotation of the operand, or a wrong realignment makes a fault-free product disagree with itself, so `error` rises on the very next `done`. Faults forced onto cell outputs must raise `error` at that same `done` whenever they disturb a bit. They must never leave an unflagged wrong product.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Sequencer phases: idle, normal-reduction pass, alternate-reduction pass.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2
  } dpc_state_e;

endpackage

// File: rtl/dpc_cell.sv
module dpc_cell (
  input  logic a_in,
  input  logic b_in,
  input  logic c_in,
  output logic a_out,
  output logic c_out
);

  // Multiplier bit passes through the row; partial sum accumulates downward.
  assign a_out = a_in;
  assign c_out = c_in ^ (a_in & b_in);

endmodule

// File: rtl/dpc_array.sv
module dpc_array #(
  parameter int WIDTH = 7,
  parameter int TAP   = 3
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  logic             alt_red,
  output logic [WIDTH-1:0] c_vec,
  output logic             a_bad
);

  localparam int LAST = WIDTH - 1;
  localparam int FB   = WIDTH - TAP - 1;

  logic [WIDTH-1:0] b_row [WIDTH];
  logic [WIDTH-1:0] c_row [WIDTH+1];
  logic [WIDTH-1:0] row_bad;

  // Multiply-by-x in either coordinate: a rotate plus one feedback XOR,
  // at bit TAP for the normal reduction, at bit 0 for the alternate one.
  function automatic logic [WIDTH-1:0] step_x(input logic [WIDTH-1:0] v,
                                              input logic alt);
    logic [WIDTH-1:0] r;
    r = {v[WIDTH-2:0], v[WIDTH-1]};
    if (alt) r[0]   = r[0]   ^ v[FB];
    else     r[TAP] = r[TAP] ^ v[WIDTH-1];
    return r;
  endfunction

  assign b_row[0] = b_vec;
  assign c_row[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    logic [WIDTH:0] a_link;
    assign a_link[0] = a_vec[i];

    for (genvar j = 0; j < WIDTH; j++) begin : g_col
      dpc_cell u_cell (
        .a_in  (a_link[j]),
        .b_in  (b_row[i][j]),
        .c_in  (c_row[i][j]),
        .a_out (a_link[j+1]),
        .c_out (c_row[i+1][j])
      );
    end

    // Row-level pass-through check: bit entering vs bit leaving the row.
    assign row_bad[i] = a_link[WIDTH] ^ a_vec[i];

    if (i < LAST) begin : g_next
      assign b_row[i+1] = step_x(b_row[i], alt_red);
    end
  end

  assign c_vec = c_row[WIDTH];
  assign a_bad = |row_bad;

endmodule

// File: rtl/dpc_realign_cmp.sv
module dpc_realign_cmp #(
  parameter int WIDTH = 7,
  parameter int TAP   = 3
) (
  input  logic [WIDTH-1:0] first_res,
  input  logic [WIDTH-1:0] second_res,
  output logic             same
);

  logic [WIDTH-1:0] aligned;

  // The rotated pass holds coefficient k at position (k - TAP) mod WIDTH.
  for (genvar k = 0; k < WIDTH; k++) begin : g_map
    assign aligned[k] = second_res[(k + WIDTH - TAP) % WIDTH];
  end

  assign same = (aligned == first_res);

endmodule

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             arr_a_bad,
  input  logic [WIDTH-1:0] arr_c,
  input  logic             cmp_same,
  output logic [WIDTH-1:0] a_hold,
  output logic [WIDTH-1:0] b_hold,
  output logic             alt_red,
  output logic [WIDTH-1:0] first_res,
  output logic             done,
  output logic [WIDTH-1:0] product,
  output logic             error
);

  dpc_state_e       st_q, st_d;
  logic             accept, cap_first, finish, check_bad;
  logic [WIDTH-1:0] a_q, b_q, c1_q;
  logic             abad1_q;
  logic             done_q, done_d;
  logic [WIDTH-1:0] prod_q, prod_d;
  logic             err_q, err_d;

  // ---------------- next-state logic ----------------
  always_comb begin
    accept    = start && (st_q != ST_PASS1);
    cap_first = (st_q == ST_PASS1);
    finish    = (st_q == ST_PASS2);
    st_d      = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_PASS1;
      ST_PASS1: st_d = ST_PASS2;
      ST_PASS2: st_d = accept ? ST_PASS1 : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    check_bad = !cmp_same || arr_a_bad || abad1_q;
    done_d    = finish;
    prod_d    = prod_q;
    err_d     = err_q;
    if (finish) begin
      err_d  = check_bad;
      prod_d = check_bad ? '0 : c1_q;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      prod_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      prod_q <= prod_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q    <= '0;
      abad1_q <= 1'b0;
    end else if (cap_first) begin
      c1_q    <= arr_c;
      abad1_q <= arr_a_bad;
    end
  end

  assign a_hold    = a_q;
  assign b_hold    = b_q;
  assign alt_red   = (st_q == ST_PASS2);
  assign first_res = c1_q;
  assign done      = done_q;
  assign product   = prod_q;
  assign error     = err_q;

  // ---------------- assertions ----------------
  p_pass_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PASS1) |=> (st_q == ST_PASS2));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_after_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(st_q) == ST_PASS2));

  p_busy_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PASS1 && start) |=> ($stable(a_q) && $stable(b_q)));

  p_zero_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (prod_q == '0));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(prod_q) && $stable(err_q)));

endmodule

// File: rtl/dpc_mul.sv
module dpc_mul #(
  parameter int WIDTH = 7,
  parameter int TAP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             done,
  output logic [WIDTH-1:0] product,
  output logic             error
);

  logic             rst_meta, rst_sync;
  logic [WIDTH-1:0] a_hold, b_hold, b_rot, arr_b, arr_c, first_res;
  logic             alt_red, arr_a_bad, cmp_same;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // Operand for the alternate pass: v_i = b_((i+TAP) mod WIDTH).
  for (genvar i = 0; i < WIDTH; i++) begin : g_rot
    assign b_rot[i] = b_hold[(i + TAP) % WIDTH];
  end

  assign arr_b = alt_red ? b_rot : b_hold;

  dpc_array #(.WIDTH(WIDTH), .TAP(TAP)) u_arr (
    .a_vec   (a_hold),
    .b_vec   (arr_b),
    .alt_red (alt_red),
    .c_vec   (arr_c),
    .a_bad   (arr_a_bad)
  );

  dpc_realign_cmp #(.WIDTH(WIDTH), .TAP(TAP)) u_cmp (
    .first_res  (first_res),
    .second_res (arr_c),
    .same       (cmp_same)
  );

  dpc_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start     (start),
    .op_a      (op_a),
    .op_b      (op_b),
    .arr_a_bad (arr_a_bad),
    .arr_c     (arr_c),
    .cmp_same  (cmp_same),
    .a_hold    (a_hold),
    .b_hold    (b_hold),
    .alt_red   (alt_red),
    .first_res (first_res),
    .done      (done),
    .product   (product),
    .error     (error)
  );

endmodule

// File: tb/test_dpc_mul.sv
module test_dpc_mul;

  localparam int W = 7;
  localparam int T = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] op_a, op_b;
  logic         done, error;
  logic [W-1:0] product;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;
  logic stuck_v = 1'b0;

  logic [W-1:0] obs_p;
  logic         obs_e, obs_d, mid_d;

  always #5 clk = ~clk;

  dpc_mul #(.WIDTH(W), .TAP(T)) i_dpc_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .done    (done),
    .product (product),
    .error   (error)
  );

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] acc, t;
    logic hi;
    acc = '0;
    t   = b;
    for (int i = 0; i < W; i++) begin
      if (a[i]) acc ^= t;
      hi = t[W-1];
      t  = {t[W-2:0], 1'b0};
      if (hi) t ^= W'((1 << T) | 1);
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); op_a = a; op_b = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); mid_d = done;
    @(negedge clk); obs_d = done; obs_p = product; obs_e = error;
  endtask

  task automatic expect_ok(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    run_op(a, b);
    chk(obs_d == 1'b1, {req, " done"}, obs_d, 1);
    chk(obs_e == 1'b0, {req, " error"}, obs_e, 0);
    chk(obs_p == ref_mul(a, b), {req, " product"}, obs_p, ref_mul(a, b));
  endtask

  task automatic expect_err(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    run_op(a, b);
    chk(obs_d == 1'b1, {req, " done"}, obs_d, 1);
    chk(obs_e == 1'b1, {req, " error"}, obs_e, 1);
    chk(obs_p == '0, "R7 product zero on error", obs_p, 0);
  endtask

  // Fault sites: 0..3 accumulate outputs, 4..5 pass-through outputs.
  task automatic force_site(input int s);
    case (s)
      0: force i_dpc_mul.u_arr.g_row[0].g_col[0].u_cell.c_out = stuck_v;
      1: force i_dpc_mul.u_arr.g_row[2].g_col[4].u_cell.c_out = stuck_v;
      2: force i_dpc_mul.u_arr.g_row[6].g_col[6].u_cell.c_out = stuck_v;
      3: force i_dpc_mul.u_arr.g_row[4].g_col[1].u_cell.c_out = stuck_v;
      4: force i_dpc_mul.u_arr.g_row[1].g_col[2].u_cell.a_out = stuck_v;
      default: force i_dpc_mul.u_arr.g_row[5].g_col[6].u_cell.a_out = stuck_v;
    endcase
  endtask

  task automatic release_site(input int s);
    case (s)
      0: release i_dpc_mul.u_arr.g_row[0].g_col[0].u_cell.c_out;
      1: release i_dpc_mul.u_arr.g_row[2].g_col[4].u_cell.c_out;
      2: release i_dpc_mul.u_arr.g_row[6].g_col[6].u_cell.c_out;
      3: release i_dpc_mul.u_arr.g_row[4].g_col[1].u_cell.c_out;
      4: release i_dpc_mul.u_arr.g_row[1].g_col[2].u_cell.a_out;
      default: release i_dpc_mul.u_arr.g_row[5].g_col[6].u_cell.a_out;
    endcase
  endtask

  function automatic int col_of(input int s);
    case (s)
      0: return 0;
      1: return 4;
      2: return 6;
      default: return 1;
    endcase
  endfunction

  task automatic t_reset();
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(error == 1'b0, "R1 error after reset", error, 0);
    chk(product == '0, "R1 product after reset", product, 0);
  endtask

  task automatic t_plain();
    expect_ok(7'h00, 7'h00, "R2 zero");
    expect_ok(7'h7f, 7'h7f, "R2 all ones");
    expect_ok(7'h01, 7'h5a, "R2 unit");
    expect_ok(7'h40, 7'h40, "R2 top bits");
    expect_ok(7'h08, 7'h10, "R6 fault-free realign");
    for (int k = 0; k < 12; k++) begin
      expect_ok(W'($urandom), W'($urandom), "R2 random");
    end
  endtask

  task automatic t_timing();
    run_op(7'h33, 7'h2d);
    chk(mid_d == 1'b0, "R3 done not early", mid_d, 0);
    chk(obs_d == 1'b1, "R3 done on second edge", obs_d, 1);
    @(negedge clk);
    chk(done == 1'b0, "R3 done single cycle", done, 0);
  endtask

  task automatic t_b2b();
    logic [W-1:0] g1, g2;
    g1 = ref_mul(7'h1b, 7'h66);
    g2 = ref_mul(7'h71, 7'h0e);
    @(negedge clk); op_a = 7'h1b; op_b = 7'h66; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); op_a = 7'h71; op_b = 7'h0e; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b1, "R4 first done", done, 1);
    chk(product == g1, "R4 first product", product, g1);
    @(negedge clk);
    chk(done == 1'b0, "R4 gap cycle", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R4 second done", done, 1);
    chk(product == g2, "R4 second product", product, g2);
  endtask

  task automatic t_busy();
    logic [W-1:0] g1;
    g1 = ref_mul(7'h25, 7'h4c);
    @(negedge clk); op_a = 7'h25; op_b = 7'h4c; start = 1'b1;
    @(negedge clk); op_a = 7'h7e; op_b = 7'h13;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R5 done of running op", done, 1);
    chk(product == g1, "R5 result unaltered", product, g1);
    @(negedge clk);
    chk(done == 1'b0, "R5 no extra done", done, 0);
    @(negedge clk);
    chk(done == 1'b0, "R5 no late done", done, 0);
    chk(product == g1, "R5 product kept", product, g1);
  endtask

  task automatic t_hold();
    logic [W-1:0] g;
    g = ref_mul(7'h5c, 7'h39);
    run_op(7'h5c, 7'h39);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); op_a = W'($urandom); op_b = W'($urandom);
      chk(product == g && error == 1'b0 && done == 1'b0, "R8 hold",
          product, g);
    end
  endtask

  task automatic t_cfault(input int s);
    int j;
    j = col_of(s);
    stuck_v = 1'b1;
    force_site(s);
    expect_err(7'h00, 7'h55, "R9 stuck-1 accumulate");
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      run_op(a, b);
      if (obs_e == 1'b0)
        chk(obs_p == ref_mul(a, b), "R9 no silent corruption", obs_p, ref_mul(a, b));
      else
        chk(obs_p == '0, "R7 product zero on error", obs_p, 0);
    end
    release_site(s);
    stuck_v = 1'b0;
    force_site(s);
    expect_err(7'h01, W'(1 << j), "R9 stuck-0 accumulate");
    expect_ok(7'h00, 7'h00, "R6 inactive fault no alarm");
    release_site(s);
    expect_ok(7'h6b, 7'h2f, "R2 after release");
  endtask

  task automatic t_afault(input int s, input int row);
    logic [W-1:0] a_hi, a_lo;
    a_hi = 7'h2a | W'(1 << row);
    a_lo = 7'h55 & ~W'(1 << row);
    stuck_v = 1'b1;
    force_site(s);
    expect_err(a_lo, 7'h3c, "R10 pass-through stuck-1");
    expect_ok(a_hi, 7'h3c, "R10 stuck-1 matches bit");
    release_site(s);
    stuck_v = 1'b0;
    force_site(s);
    expect_err(a_hi, 7'h47, "R10 pass-through stuck-0");
    expect_ok(a_lo, 7'h47, "R10 stuck-0 matches bit");
    release_site(s);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && error == 1'b0 && product == '0, "R1 during reset", product, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_timing();
    t_b2b();
    t_busy();
    t_hold();
    for (int s = 0; s < 4; s++) t_cfault(s);
    t_afault(4, 1);
    t_afault(5, 5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule